// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block holds the interrupt flags of a USB device controller. Single-cycle event pulses from the endpoint logic are latched into sticky flags. The CPU reads the flags, then acknowledges each event by writing 0 to its bit. Bit 3 is not a flag: it is a live view of the cable-connection pin, brought in through a two-flop synchronizer.

Two configuration registers sit beside the flag register. The enable register gates each flag. The select register steers each enabled flag to one of two level-sensitive interrupt request lines. Each line is the OR of every flag that is set, enabled and steered to it, so a line stays high until the CPU clears the flags behind it.

The CPU port is synchronous, with a 2-bit address, a write strobe, write data and combinational read data. The address map is: 0 selects the flag and status register, 1 the enable register, 2 the select register, and 3 is unused.

Top module: `usbf_irq_flags`

## Requirements
- R1: Bits 7 to 4 and bit 1 of the flag register read as 0 and ignore writes. Address 3 reads as 0.
- R2: Bit 3 of address 0 is read-only. It shows the connection pin as sampled by two clock edges (1 = connected, 0 = disconnected), so a change on the pin appears after the second rising edge.
- R3: Bit 2 is set at the clock edge on which `ev_ep3_in_empty` is high, and stays set after the pulse ends.
- R4: Bit 0 is set at the clock edge on which `ev_ep0_tx_done` is high, and stays set after the pulse ends.
- R5: A write to address 0 clears each flag whose write-data bit is 0. A flag whose write-data bit is 1 keeps its value.
- R6: When an event and a clearing write reach the same flag on the same edge, the flag ends up set.
- R7: After reset, all flags, the enable register and the select register read 0, and both interrupt lines are low.
- R8: `irq_line0` is high exactly when some flag is 1 with its enable bit 1 and its select bit 0. `irq_line1` is the same with the select bit 1.
- R9: Addresses 1 (enable) and 2 (select) store and read back only bits 0 and 2. All their other bits read as 0, so the status bit can never raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ev_ep0_tx_done | input | 1 | Pulse: endpoint 0 IN data was sent and acknowledged |
| ev_ep3_in_empty | input | 1 | Pulse: IN token to endpoint 3 found its FIFO empty |
| vbus_pin | input | 1 | Asynchronous cable-connection pin |
| irq_line0 | output | 1 | Interrupt request line 0 (level) |
| irq_line1 | output | 1 | Interrupt request line 1 (level) |

## Verification
The assertions assume that the event inputs are synchronous to `clk`. They assume the connection pin may change at any time, but they compare the status bit with the pin only once two edges have passed since reset. The bench drives every input on the falling clock edge and holds each event high for exactly one rising edge. It keeps the pin low through reset and reads the status only after the synchronizer delay. Same-edge set and clear collisions are produced on purpose, so the set-priority property is exercised and not only assumed.

// File: rtl/usbf_irq_pkg.sv
package usbf_irq_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned ADDR_W     = 2;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd0;
   localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
   localparam logic [ADDR_W-1:0] A_SELECT = 2'd2;
   localparam int unsigned B_EP0_DONE = 0;
   localparam int unsigned B_EP3_EMPTY = 2;
   localparam int unsigned B_VBUS     = 3;
   localparam logic [REG_W-1:0] FLAG_BITS = 8'h05;
endpackage

// File: rtl/usbf_sync2.sv
module usbf_sync2 #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("usbf_sync2: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/usbf_flag_bank.sv
module usbf_flag_bank #(
   parameter int unsigned         W    = 8,
   parameter logic [W-1:0]        MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_ev,
   input  logic         clr_wr,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] flag_q
);
   if (W < 4) begin : g_bad_width
      $error("usbf_flag_bank: W must be at least 4");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)                    flag_q[i] <= 1'b0;
            else if (set_ev[i])            flag_q[i] <= 1'b1;
            else if (clr_wr && !clr_data[i]) flag_q[i] <= 1'b0;
         end
      end else begin : g_tied
         logic unused_in;
         assign unused_in = set_ev[i] ^ clr_data[i];
         assign flag_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/usbf_irq_route.sv
module usbf_irq_route #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] flags,
   input  logic [W-1:0] enable,
   input  logic [W-1:0] select,
   output logic         irq0,
   output logic         irq1
);
   logic [W-1:0] hit0, hit1;

   for (genvar i = 0; i < W; i++) begin : g_route
      assign hit0[i] = flags[i] & enable[i] & ~select[i];
      assign hit1[i] = flags[i] & enable[i] &  select[i];
   end

   assign irq0 = |hit0;
   assign irq1 = |hit1;
endmodule

// File: rtl/usbf_irq_flags.sv
module usbf_irq_flags
   import usbf_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              ev_ep0_tx_done,
   input  logic              ev_ep3_in_empty,
   input  logic              vbus_pin,
   output logic              irq_line0,
   output logic              irq_line1
);
   if (B_VBUS >= REG_W || FLAG_BITS[B_VBUS]) begin : g_bad_map
      $error("usbf_irq_flags: status bit must be inside the register and not a flag");
   end

   logic [REG_W-1:0] set_ev;
   logic [REG_W-1:0] flag_q;
   logic [REG_W-1:0] en_q, sel_q;
   logic             vbus_s;
   logic             wr_flags;

   always_comb begin
      set_ev              = '0;
      set_ev[B_EP0_DONE]  = ev_ep0_tx_done;
      set_ev[B_EP3_EMPTY] = ev_ep3_in_empty;
   end

   assign wr_flags = reg_wr && (reg_addr == A_FLAGS);

   usbf_sync2 #(.STAGES(SYNC_STAGES)) vbus_sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (vbus_pin),
      .q_sync  (vbus_s)
   );

   usbf_flag_bank #(.W(REG_W), .MASK(FLAG_BITS)) flags_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ev   (set_ev),
      .clr_wr   (wr_flags),
      .clr_data (reg_wdata),
      .flag_q   (flag_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         sel_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_ENABLE) en_q  <= reg_wdata & FLAG_BITS;
         if (reg_addr == A_SELECT) sel_q <= reg_wdata & FLAG_BITS;
      end
   end

   usbf_irq_route #(.W(REG_W)) route_i (
      .flags  (flag_q),
      .enable (en_q),
      .select (sel_q),
      .irq0   (irq_line0),
      .irq1   (irq_line1)
   );

   always_comb begin
      unique case (reg_addr)
         A_FLAGS: begin
            reg_rdata         = flag_q;
            reg_rdata[B_VBUS] = vbus_s;
         end
         A_ENABLE: reg_rdata = en_q;
         A_SELECT: reg_rdata = sel_q;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/usbf_irq_flags_chk.sv
module usbf_irq_flags_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] reg_addr,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic       ev_ep0_tx_done,
   input logic       ev_ep3_in_empty,
   input logic       vbus_pin,
   input logic       irq_line0,
   input logic       irq_line1,
   input logic [7:0] flag_q,
   input logic [7:0] en_q,
   input logic [7:0] sel_q
);
   logic [1:0] age_q;
   logic       wr0;

   always_ff @(posedge clk) begin
      if (!rst_n)             age_q <= '0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   assign wr0 = reg_wr && (reg_addr == 2'd0);

   p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7:4] == 4'h0) && !reg_rdata[1]);

   p_vbus_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && reg_addr == 2'd0) |-> (reg_rdata[3] == $past(vbus_pin, 2)));

   p_ep3_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ep3_in_empty |=> flag_q[2]);

   p_ep0_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ep0_tx_done |=> flag_q[0]);

   p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && !reg_wdata[0] && !ev_ep0_tx_done) |=> !flag_q[0]);

   p_write_one_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && reg_wdata[2] && !ev_ep3_in_empty) |=> $stable(flag_q[2]));

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && !reg_wdata[2] && ev_ep3_in_empty) |=> flag_q[2]);

   p_line0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && en_q[0] && !sel_q[0]) |-> irq_line0);

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & en_q) == 8'h00) |-> (!irq_line0 && !irq_line1));

   p_cfg_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q | sel_q) & 8'hFA) == 8'h00);
endmodule

bind usbf_irq_flags usbf_irq_flags_chk chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .reg_addr        (reg_addr),
   .reg_wr          (reg_wr),
   .reg_wdata       (reg_wdata),
   .reg_rdata       (reg_rdata),
   .ev_ep0_tx_done  (ev_ep0_tx_done),
   .ev_ep3_in_empty (ev_ep3_in_empty),
   .vbus_pin        (vbus_pin),
   .irq_line0       (irq_line0),
   .irq_line1       (irq_line1),
   .flag_q          (flag_q),
   .en_q            (en_q),
   .sel_q           (sel_q)
);

// File: tb/usbf_irq_flags_tb.sv
module usbf_irq_flags_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] reg_addr;
   logic       reg_wr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       ev_ep0_tx_done, ev_ep3_in_empty, vbus_pin;
   logic       irq_line0, irq_line1;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   usbf_irq_flags dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .reg_addr        (reg_addr),
      .reg_wr          (reg_wr),
      .reg_wdata       (reg_wdata),
      .reg_rdata       (reg_rdata),
      .ev_ep0_tx_done  (ev_ep0_tx_done),
      .ev_ep3_in_empty (ev_ep3_in_empty),
      .vbus_pin        (vbus_pin),
      .irq_line0       (irq_line0),
      .irq_line1       (irq_line1)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input bit ep0, input bit ep3);
      @(negedge clk);
      ev_ep0_tx_done = ep0; ev_ep3_in_empty = ep3;
      @(negedge clk);
      ev_ep0_tx_done = 1'b0; ev_ep3_in_empty = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd0, d); check("R7 flags", d, 8'h00);
      rd(2'd1, d); check("R7 enable", d, 8'h00);
      rd(2'd2, d); check("R7 select", d, 8'h00);
      check("R7 irq lines", {6'd0, irq_line1, irq_line0}, 8'h00);
   endtask

   task automatic t_reserved();
      logic [7:0] d;
      wr(2'd0, 8'hFF);
      rd(2'd0, d); check("R1 reserved after write", d, 8'h00);
      wr(2'd3, 8'hFF);
      rd(2'd3, d); check("R1 addr3", d, 8'h00);
   endtask

   task automatic t_cfg();
      logic [7:0] d;
      wr(2'd1, 8'hFF);
      rd(2'd1, d); check("R9 enable readback", d, 8'h05);
      wr(2'd2, 8'hFF);
      rd(2'd2, d); check("R9 select readback", d, 8'h05);
      wr(2'd1, 8'h00); wr(2'd2, 8'h00);
   endtask

   task automatic t_vbus();
      logic [7:0] d;
      @(negedge clk); vbus_pin = 1'b1;
      reg_addr = 2'd0;
      @(negedge clk); rd(2'd0, d); check("R2 after one edge", d & 8'h08, 8'h00);
      @(negedge clk); rd(2'd0, d); check("R2 after two edges", d & 8'h08, 8'h08);
      wr(2'd0, 8'h00);
      rd(2'd0, d); check("R2 read-only", d & 8'h08, 8'h08);
      @(negedge clk); vbus_pin = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd0, d); check("R2 disconnect", d & 8'h08, 8'h00);
   endtask

   task automatic t_events();
      logic [7:0] d;
      pulse(1'b0, 1'b1);
      repeat (3) @(negedge clk);
      rd(2'd0, d); check("R3 ep3 sticky", d, 8'h04);
      pulse(1'b1, 1'b0);
      rd(2'd0, d); check("R4 ep0 set", d, 8'h05);
      wr(2'd0, 8'hFE);
      rd(2'd0, d); check("R5 clear bit0 keep bit2", d, 8'h04);
      wr(2'd0, 8'hFB);
      rd(2'd0, d); check("R5 clear bit2", d, 8'h00);
      wr(2'd0, 8'h05);
      rd(2'd0, d); check("R5 write one no set", d, 8'h00);
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      pulse(1'b1, 1'b0);
      @(negedge clk);
      reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
      ev_ep3_in_empty = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ev_ep3_in_empty = 1'b0;
      rd(2'd0, d); check("R6 set beats clear", d, 8'h04);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_route();
      wr(2'd2, 8'h04);
      pulse(1'b1, 1'b1);
      check("R8 disabled lines", {6'd0, irq_line1, irq_line0}, 8'h00);
      wr(2'd1, 8'h05);
      check("R8 both lines", {6'd0, irq_line1, irq_line0}, 8'h03);
      wr(2'd0, 8'hFE);
      check("R8 line0 drops", {6'd0, irq_line1, irq_line0}, 8'h02);
      wr(2'd2, 8'h00);
      check("R8 resteer to line0", {6'd0, irq_line1, irq_line0}, 8'h01);
      wr(2'd0, 8'h00);
      check("R8 all clear", {6'd0, irq_line1, irq_line0}, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
      ev_ep0_tx_done = 1'b0; ev_ep3_in_empty = 1'b0; vbus_pin = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_reserved();
      t_cfg();
      t_vbus();
      t_events();
      t_set_wins();
      t_route();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule